// File: doc/BRIEF.md
# DMA Channel Service Arbiter

This block decides which of a set of DMA channels is started next by a shared data-movement engine. Every cycle it samples one request line per channel together with a small control field per channel: a 4-bit priority level, a flag that lets the channel be suspended while it runs, and a flag that forbids the channel from suspending others. A global mode input selects between fixed-priority selection and round-robin selection. The chosen channel is presented on a registered grant port one cycle later, with a single-cycle valid strobe.

While the engine reports that a channel is running, normal grants are held back. In fixed-priority mode a waiting channel with a strictly higher level may still be granted, with a preempt strobe asking the engine to suspend the running channel. The preempt strobe requires the running channel to be suspendable and the requester to be allowed to suspend others. A configuration-error flag reports duplicate priority levels in fixed-priority mode. A debug input stalls new starts and preemptions without touching a running channel. A halt input blocks all service. When halt-on-error is enabled, an error latches an internal halt that stays until it is cleared.

The block also provides the address swizzle software needs to find a channel's control byte. Within each aligned group of four channels the bytes are stored in reverse order.

Top module: `dma_chan_arb`

## Requirements
- R1: After reset, grant_valid_o, preempt_o and prio_err_o are 0.
- R2: In fixed-priority mode (rr_mode_i=0) with busy_i=0, one cycle after requests are sampled grant_valid_o is 1 and grant_ch_o is the requesting channel with the largest level. The level is bits [3:0] of the channel's 6-bit control field in prio_cfg_i. On equal levels the lower channel number wins.
- R3: In round-robin mode (rr_mode_i=1) the search starts at the channel after the last granted one and wraps around. Levels are ignored. After reset the search starts at channel 0.
- R4: While busy_i=1, no grant is issued unless it is a preempting grant.
- R5: In fixed-priority mode with busy_i=1, preempt_o and grant_valid_o go to 1 one cycle later, with grant_ch_o set to the candidate channel, when all of the following hold. The candidate is the highest-level requester other than run_ch_i whose bit 4 (may-not-preempt) is 0. Its level is strictly above the level of run_ch_i. Bit 5 (suspendable) of run_ch_i is 1.
- R6: No preemption occurs in any of these cases: the running channel's bit 5 is 0, the only higher-level requester has bit 4 set, the requester's level is equal to or lower than the running level, or round-robin mode is selected.
- R7: One cycle after any two channels hold equal levels in fixed-priority mode, prio_err_o is 1. In round-robin mode it is 0.
- R8: While debug_i=1, no new grant and no preemption is issued. A running channel (busy_i) is left alone.
- R9: While halt_i=1, no grant is issued.
- R10: With halt_on_err_i=1, a cycle with err_i=1 or prio_err_o=1 latches a halt. The halt blocks all grants until a cycle with halt_clr_i=1. With halt_on_err_i=0, err_i has no effect on grants.
- R11: lane_idx_o is combinationally lane_ch_i with its low two bits replaced by 3 minus those bits. The upper bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_CH | Per-channel service request |
| prio_cfg_i | input | 6*N_CH | Per-channel control: [3:0] level, [4] may-not-preempt, [5] suspendable |
| rr_mode_i | input | 1 | 1 = round robin, 0 = fixed priority |
| halt_i | input | 1 | Block all service |
| halt_on_err_i | input | 1 | Errors latch an internal halt |
| halt_clr_i | input | 1 | Clear the latched halt |
| err_i | input | 1 | Error event from the engine |
| debug_i | input | 1 | Stall new starts and preemptions |
| busy_i | input | 1 | Engine is executing a channel |
| run_ch_i | input | log2(N_CH) | Channel currently executing |
| lane_ch_i | input | log2(N_CH) | Channel whose control byte index is looked up |
| grant_valid_o | output | 1 | Grant strobe |
| grant_ch_o | output | log2(N_CH) | Granted channel |
| preempt_o | output | 1 | Suspend the running channel in favour of grant_ch_o |
| prio_err_o | output | 1 | Duplicate levels in fixed-priority mode |
| lane_idx_o | output | log2(N_CH) | Byte index of lane_ch_i's control byte |

## Verification
Grant, preempt and error outputs are registered, so each is due exactly one clock edge after the inputs it depends on. The bench changes inputs just after a falling edge and reads outputs at the following falling edge. The latched halt adds one more edge: the error is driven first, and requests are raised only in the cycle after it. The lane index is combinational and is read a short delay after lane_ch_i changes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int LVL_W = 4;
  localparam int CFG_W = LVL_W + 2;

  typedef struct packed {
    logic             suspendable;
    logic             no_preempt;
    logic [LVL_W-1:0] level;
  } chan_cfg_t;
endpackage

// File: rtl/dma_arb_fixpick.sv
module dma_arb_fixpick
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]            mask_i,
  input  logic [N_CH-1:0][LVL_W-1:0] lvl_i,
  output logic                       found_o,
  output logic [CH_W-1:0]            idx_o
);
  logic [LVL_W-1:0] best;

  // strictly greater keeps the lower index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (mask_i[i] && (!found_o || lvl_i[i] > best)) begin
        found_o = 1'b1;
        idx_o   = CH_W'(i);
        best    = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/dma_arb_rrpick.sv
module dma_arb_rrpick #(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] mask_i,
  input  logic [CH_W-1:0] last_i,
  output logic            found_o,
  output logic [CH_W-1:0] idx_o
);
  int j;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    j       = 0;
    for (int k = 1; k <= N_CH; k++) begin
      j = (int'(last_i) + k) % N_CH;
      if (!found_o && mask_i[j]) begin
        found_o = 1'b1;
        idx_o   = CH_W'(j);
      end
    end
  end
endmodule

// File: rtl/dma_arb_uniq.sv
module dma_arb_uniq
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0][LVL_W-1:0] lvl_i,
  output logic                       dup_o
);
  always_comb begin
    dup_o = 1'b0;
    for (int a = 0; a < N_CH; a++) begin
      for (int b = a + 1; b < N_CH; b++) begin
        if (lvl_i[a] == lvl_i[b]) dup_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_lane.sv
module dma_arb_lane #(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [CH_W-1:0] ch_i,
  output logic [CH_W-1:0] idx_o
);
  // bytes reversed inside each group of four
  generate
    if (CH_W > 2) begin : g_wide
      assign idx_o = {ch_i[CH_W-1:2], 2'd3 - ch_i[1:0]};
    end else begin : g_narrow
      assign idx_o = 2'd3 - ch_i[1:0];
    end
  endgenerate
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       req_i,
  input  logic [N_CH*CFG_W-1:0] prio_cfg_i,
  input  logic                  rr_mode_i,
  input  logic                  halt_i,
  input  logic                  halt_on_err_i,
  input  logic                  halt_clr_i,
  input  logic                  err_i,
  input  logic                  debug_i,
  input  logic                  busy_i,
  input  logic [CH_W-1:0]       run_ch_i,
  input  logic [CH_W-1:0]       lane_ch_i,
  output logic                  grant_valid_o,
  output logic [CH_W-1:0]       grant_ch_o,
  output logic                  preempt_o,
  output logic                  prio_err_o,
  output logic [CH_W-1:0]       lane_idx_o
);
  logic [N_CH-1:0][LVL_W-1:0] lvl;
  logic [N_CH-1:0]            susp, nopre;

  for (genvar i = 0; i < N_CH; i++) begin : g_cfg
    chan_cfg_t c;
    assign c        = prio_cfg_i[i*CFG_W +: CFG_W];
    assign lvl[i]   = c.level;
    assign susp[i]  = c.suspendable;
    assign nopre[i] = c.no_preempt;
  end

  logic            halt_q;
  logic [CH_W-1:0] last_q;
  logic            fx_found, rr_found, pre_found, dup;
  logic [CH_W-1:0] fx_idx, rr_idx, pre_idx;
  logic [N_CH-1:0] run_oh, pre_mask;

  assign run_oh   = N_CH'(1) << run_ch_i;
  assign pre_mask = req_i & ~run_oh & ~nopre;

  dma_arb_fixpick #(.N_CH(N_CH)) u_fix (
    .mask_i(req_i), .lvl_i(lvl), .found_o(fx_found), .idx_o(fx_idx)
  );

  dma_arb_fixpick #(.N_CH(N_CH)) u_pre (
    .mask_i(pre_mask), .lvl_i(lvl), .found_o(pre_found), .idx_o(pre_idx)
  );

  dma_arb_rrpick #(.N_CH(N_CH)) u_rr (
    .mask_i(req_i), .last_i(last_q), .found_o(rr_found), .idx_o(rr_idx)
  );

  dma_arb_uniq #(.N_CH(N_CH)) u_uniq (.lvl_i(lvl), .dup_o(dup));

  dma_arb_lane #(.N_CH(N_CH)) u_lane (.ch_i(lane_ch_i), .idx_o(lane_idx_o));

  logic            stall, pre_ok, new_ok, win;
  logic [CH_W-1:0] win_ch;

  assign stall  = halt_i | halt_q | debug_i;
  assign pre_ok = !rr_mode_i && busy_i && pre_found && susp[run_ch_i] &&
                  (lvl[pre_idx] > lvl[run_ch_i]);
  assign new_ok = !busy_i && (rr_mode_i ? rr_found : fx_found);
  assign win    = !stall && (pre_ok || new_ok);
  assign win_ch = pre_ok ? pre_idx : (rr_mode_i ? rr_idx : fx_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_ch_o    <= '0;
      preempt_o     <= 1'b0;
      prio_err_o    <= 1'b0;
      halt_q        <= 1'b0;
      last_q        <= CH_W'(N_CH - 1);
    end else begin
      grant_valid_o <= win;
      preempt_o     <= win && pre_ok;
      prio_err_o    <= !rr_mode_i && dup;
      if (win) begin
        grant_ch_o <= win_ch;
        last_q     <= win_ch;
      end
      if (halt_on_err_i && (err_i || prio_err_o)) halt_q <= 1'b1;
      else if (halt_clr_i)                        halt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_CH-1:0]       req_i,
  input logic [N_CH*CFG_W-1:0] prio_cfg_i,
  input logic                  rr_mode_i,
  input logic                  halt_i,
  input logic                  halt_on_err_i,
  input logic                  halt_clr_i,
  input logic                  err_i,
  input logic                  debug_i,
  input logic                  busy_i,
  input logic [CH_W-1:0]       run_ch_i,
  input logic [CH_W-1:0]       lane_ch_i,
  input logic                  grant_valid_o,
  input logic [CH_W-1:0]       grant_ch_o,
  input logic                  preempt_o,
  input logic                  prio_err_o,
  input logic [CH_W-1:0]       lane_idx_o
);
  a_r4_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!grant_valid_o || preempt_o));

  a_r5_preempt_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> grant_valid_o);

  a_r6_rr_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_mode_i |=> !preempt_o);

  a_r7_rr_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_mode_i |=> !prio_err_o);

  a_r8_debug_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_i |=> !grant_valid_o);

  a_r9_halt_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !grant_valid_o);

  a_r2_grant_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !rr_mode_i && req_i == '0) |=> !grant_valid_o);

  a_r11_lane_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (2'(lane_idx_o[1:0] + lane_ch_i[1:0]) == 2'd3) &&
    ((lane_idx_o >> 2) == (lane_ch_i >> 2)));
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/tb_dma_chan_arb.sv
`timescale 1ns/1ps
module tb_dma_chan_arb;
  localparam int N = 8;
  localparam int CW = 3;
  localparam int FW = 6;

  logic          clk = 0, rst_n = 0;
  logic [N-1:0]  req = '0;
  logic [N*FW-1:0] cfg;
  logic          rr = 0, halt = 0, hoe = 0, hclr = 0, err = 0, dbg = 0, busy = 0;
  logic [CW-1:0] run_ch = '0, lane_ch = '0;
  logic          gv, pre, perr;
  logic [CW-1:0] gch, lane_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_chan_arb #(.N_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_cfg_i(cfg),
    .rr_mode_i(rr), .halt_i(halt), .halt_on_err_i(hoe), .halt_clr_i(hclr),
    .err_i(err), .debug_i(dbg), .busy_i(busy), .run_ch_i(run_ch),
    .lane_ch_i(lane_ch), .grant_valid_o(gv), .grant_ch_o(gch),
    .preempt_o(pre), .prio_err_o(perr), .lane_idx_o(lane_idx)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int ch, int lvl, bit susp, bit nopre);
    cfg[ch*FW +: FW] = {susp, nopre, 4'(lvl)};
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 grant_valid", gv, 0);
    check("R1 preempt", pre, 0);
    check("R1 prio_err", perr, 0);
  endtask

  task automatic t_fixed();
    req = 8'b0010_0101; step();
    check("R2 valid", gv, 1); check("R2 ch", gch, 5);
    check("R7 unique no err", perr, 0);
    set_cfg(0, 15, 0, 0); step();
    check("R2 ch level15", gch, 0);
    set_cfg(0, 0, 0, 0); req = '0; step();
    check("R2 idle", gv, 0);
  endtask

  task automatic t_rr();
    rr = 1; req = 8'b0000_0100; step();
    check("R3 single", gch, 2);
    req = 8'b1000_0101; step();
    check("R3 after 2", gch, 7); step();
    check("R3 wrap", gch, 0); step();
    check("R3 next", gch, 2);
    // round robin ignores levels: busy with preemptible run and higher requester
    set_cfg(3, 3, 1, 0); busy = 1; run_ch = 3; req = 8'b0010_0000; step();
    check("R6 rr no preempt", pre, 0);
    check("R4 rr busy no grant", gv, 0);
    set_cfg(3, 3, 0, 0); busy = 0; req = '0; rr = 0; step();
  endtask

  task automatic t_preempt();
    busy = 1; run_ch = 3; req = 8'b0010_0000; step();
    check("R4 busy no grant", gv, 0);
    check("R6 not suspendable", pre, 0);
    set_cfg(3, 3, 1, 0); set_cfg(6, 6, 0, 1);
    req = 8'b0110_0010; step();
    check("R5 preempt", pre, 1); check("R5 valid", gv, 1); check("R5 ch", gch, 5);
    req = 8'b0100_0000; step();
    check("R6 no-preempt bit", pre, 0); check("R6 no grant", gv, 0);
    req = 8'b0000_0010; step();
    check("R6 lower level", pre, 0);
    set_cfg(5, 3, 0, 0); req = 8'b0010_0000; step();
    check("R6 equal level", pre, 0);
    check("R7 dup err", perr, 1);
    rr = 1; step();
    check("R7 rr clears err", perr, 0);
    rr = 0; set_cfg(5, 5, 0, 0); set_cfg(6, 6, 0, 0);
    req = '0; busy = 0; step();
    check("R7 restored", perr, 0);
  endtask

  task automatic t_debug_halt();
    dbg = 1; req = 8'b0010_0000; step();
    check("R8 debug no start", gv, 0);
    busy = 1; step();
    check("R8 debug no preempt", pre, 0);
    busy = 0; dbg = 0; step();
    check("R8 resume", gv, 1);
    halt = 1; step();
    check("R9 halt", gv, 0);
    halt = 0; step();
    check("R9 resume", gch, 5);
    req = '0; step();
  endtask

  task automatic t_halt_err();
    hoe = 0; err = 1; req = 8'b0000_0100; step();
    err = 0; step();
    check("R10 err ignored", gv, 1);
    req = '0; hoe = 1; err = 1; step();
    err = 0; req = 8'b0000_0100; step();
    check("R10 halted", gv, 0); step();
    check("R10 still halted", gv, 0);
    hclr = 1; req = '0; step();
    hclr = 0; req = 8'b0000_0100; step();
    check("R10 cleared", gv, 1); check("R10 ch", gch, 2);
    req = '0; hoe = 0; step();
  endtask

  task automatic t_lane();
    for (int c = 0; c < N; c++) begin
      lane_ch = CW'(c); #1;
      check("R11 lane", lane_idx, (c & ~3) | (3 - (c & 3)));
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) set_cfg(i, i, 0, 0);
    #2; t_reset();
    #20; @(negedge clk); rst_n = 1; step();
    t_reset();
    t_fixed();
    t_rr();
    t_preempt();
    t_debug_halt();
    t_halt_err();
    t_lane();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule